// File: doc/BRIEF.md
# Frame Input Offset Meter

This block measures how far an evaluation input lags a frame boundary, with a resolution of half a bit-clock period. It runs on a single clock `clk` whose period equals half of a serial bit period. Each `clk` cycle is therefore one half bit period. The first half of each bit period is the high clock phase and the second half is the low clock phase. A one-cycle `frame_pulse` marks each frame boundary. The evaluation input `eval_n` is active low.

A measurement is armed by software through the `start` level. `start` must stay low while a set number of frame pulses go by, and then it must rise. After that accepted rising edge, the block waits for the next frame boundary. From that boundary it counts half periods until it first samples `eval_n` low. It then reports the whole bit periods in `delay_cnt`, reports the sampled phase in `half_phase`, and raises `done`. The result stays readable until the next accepted start. If no low level arrives before the next frame boundary, the result saturates.

Top module: `frame_offset_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `delay_cnt` and `half_phase` become 0.
- R2: A rising edge of `start` is accepted only if `start` was low while at least ARM_FRAMES (default 2) frame pulses were sampled. Any other rising edge is ignored: `done`, `delay_cnt` and `half_phase` keep their values, and later `eval_n` activity has no effect on them.
- R3: In the cycle after an accepted rising edge, `done`, `delay_cnt` and `half_phase` are all 0.
- R4: Counting starts at the first `frame_pulse` after acceptance, and that cycle has half index 0. `eval_n` is sampled in every cycle. The first cycle with `eval_n` low fixes the half index h, counted in cycles after the frame pulse cycle.
- R5: `delay_cnt` reports floor(h/2) as an unsigned binary number with its most significant bit at index CNT_W-1.
- R6: `half_phase` is 1 when h is even, meaning the sample fell in the high clock phase. It is 0 when h is odd, meaning the sample fell in the low clock phase.
- R7: `done` rises in the cycle after the capturing sample. After that, `done`, `delay_cnt` and `half_phase` hold their values until the next accepted start, whatever `eval_n` and `frame_pulse` do.
- R8: Saturation happens when `frame_pulse` arrives again before any low sample, or when the half counter reaches its all-ones value. The block then sets `delay_cnt` to all ones, `half_phase` to 1 and `done` to 1.
- R9: If `start` falls after acceptance and before a result, the measurement is abandoned. `done` stays 0 and the cleared result stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-period clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame boundary strobe |
| eval_n | input | 1 | Active-low evaluation input |
| start | input | 1 | Software start control level |
| delay_cnt | output | CNT_W | Measured offset in whole bit periods |
| half_phase | output | 1 | 1 = sampled in high phase, 0 = low phase |
| done | output | 1 | Result valid |

## Verification
The bench sweeps the half index across a whole frame, from 0 to 47. This catches three kinds of error: an off-by-one in where counting starts, a phase bit that is swapped, and a delay that is not halved correctly. It starts measurements with too short a low period of `start` and expects nothing to change; a design that does not check the arming condition would overwrite the held result. It also covers both ways of saturating: a second frame pulse, and a counter that runs to all ones. A design missing either one would hang with `done` low or wrap the count. It drops `start` in the middle of a measurement; a design that misses the abort would report a stale or false result.

// File: rtl/fom_pkg.sv
// Shared types for the frame offset meter.
package fom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } fom_state_e;
endpackage

// File: rtl/fom_arm.sv
// Start qualification: detects both edges of the start level and tracks
// how many frame pulses have been seen while start is low.
// Assumes start is already synchronous to clk.
module fom_arm #(
    parameter int ARM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic frame_pulse,
    output logic start_rise,
    output logic start_fall,
    output logic armed
);
    localparam int ARM_W = $clog2(ARM_FRAMES + 1);
    localparam logic [ARM_W-1:0] ARM_LIM = ARM_W'(ARM_FRAMES);

    logic             start_q;
    logic [ARM_W-1:0] low_frames;

    // Remember the previous start level so that edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Count frame pulses seen while start is low, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_frames <= '0;
        else if (start)
            low_frames <= '0;
        else if (frame_pulse && (low_frames != ARM_LIM))
            low_frames <= low_frames + 1'b1;
    end

    assign start_rise = start & ~start_q;
    assign start_fall = ~start & start_q;
    assign armed      = (low_frames == ARM_LIM);

    // R2
    arm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_frames <= ARM_LIM);
    // R2
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !armed);
endmodule

// File: rtl/fom_halfcnt.sv
// Half-period counter: cleared on acceptance, advanced once per sampled
// half period. It flags all-ones so that the caller can saturate.
module fom_halfcnt #(
    parameter int HC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    output logic [HC_W-1:0] cnt,
    output logic            full
);
    // Clear or advance the half-period index.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign full = &cnt;

    // R8
    hc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> (cnt != '0));
endmodule

// File: rtl/fom_capture.sv
// Result register: clears on acceptance, captures the half index split into
// whole periods and phase, or loads the saturated code. Holds otherwise.
module fom_capture #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lat,
    input  logic             sat,
    input  logic [CNT_W:0]   half_idx,
    output logic [CNT_W-1:0] delay_cnt,
    output logic             half_phase,
    output logic             done
);
    // Update the result fields and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            delay_cnt  <= '0;
            half_phase <= 1'b0;
            done       <= 1'b0;
        end else if (sat) begin
            delay_cnt  <= '1;
            half_phase <= 1'b1;
            done       <= 1'b1;
        end else if (lat) begin
            delay_cnt  <= half_idx[CNT_W:1];
            half_phase <= ~half_idx[0];
            done       <= 1'b1;
        end
    end

    // R8
    sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> (done && half_phase && (&delay_cnt)));
endmodule

// File: rtl/frame_offset_meter.sv
// Frame input offset meter. After a qualified rising edge of start, it
// waits for a frame boundary, counts half bit periods (one per clk) until
// eval_n is first sampled low, and reports whole periods plus the phase.
// Assumes: clk period is half a bit period; frame_pulse is a 1-cycle strobe.
module frame_offset_meter
    import fom_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int ARM_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             eval_n,
    input  logic             start,
    output logic [CNT_W-1:0] delay_cnt,
    output logic             half_phase,
    output logic             done
);
    localparam int HC_W = CNT_W + 1;

    fom_state_e      state, nxt;
    logic            start_rise, start_fall, armed, accept;
    logic            hc_inc, hc_full, cap_lat, cap_sat;
    logic [HC_W-1:0] hc_cnt;

    fom_arm #(.ARM_FRAMES(ARM_FRAMES)) u_arm (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_pulse(frame_pulse),
        .start_rise(start_rise), .start_fall(start_fall), .armed(armed)
    );

    assign accept = start_rise & armed & (state == ST_IDLE);

    fom_halfcnt #(.HC_W(HC_W)) u_hc (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(hc_inc),
        .cnt(hc_cnt), .full(hc_full)
    );

    fom_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(accept), .lat(cap_lat), .sat(cap_sat),
        .half_idx(hc_cnt), .delay_cnt(delay_cnt), .half_phase(half_phase),
        .done(done)
    );

    // Measurement sequencing: wait for a boundary, then sample each half period.
    always_comb begin
        nxt     = state;
        hc_inc  = 1'b0;
        cap_lat = 1'b0;
        cap_sat = 1'b0;
        case (state)
            ST_IDLE: if (accept) nxt = ST_WAIT;
            ST_WAIT: begin
                if (start_fall) nxt = ST_IDLE;
                else if (frame_pulse) begin
                    if (!eval_n) begin
                        cap_lat = 1'b1;
                        nxt     = ST_IDLE;
                    end else begin
                        hc_inc = 1'b1;
                        nxt    = ST_MEAS;
                    end
                end
            end
            ST_MEAS: begin
                if (start_fall) nxt = ST_IDLE;
                else if (frame_pulse || (eval_n && hc_full)) begin
                    cap_sat = 1'b1;
                    nxt     = ST_IDLE;
                end else if (!eval_n) begin
                    cap_lat = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    hc_inc = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R3
    accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && delay_cnt == '0 && !half_phase));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |=> (done && $stable(delay_cnt) && $stable(half_phase)));
    // R2
    unarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_rise && !armed) |=> (state == ST_IDLE));
    // R9
    busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !done);
    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_fall) |=> (state == ST_IDLE && !done));
endmodule

// File: tb/tb_frame_offset_meter.sv
module tb_frame_offset_meter;
    localparam int PER   = 10;
    localparam int CW    = 6;
    localparam int FRAME = 48;
    localparam int SATV  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n, frame_pulse, eval_n, start;
    logic [CW-1:0] delay_cnt;
    logic          half_phase, done;
    int checks = 0;
    int errors = 0;

    frame_offset_meter #(.CNT_W(CW), .ARM_FRAMES(2)) dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .eval_n(eval_n),
        .start(start), .delay_cnt(delay_cnt), .half_phase(half_phase), .done(done)
    );

    always #(PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_res(input string req, input int d, input int p, input int dn);
        chk(delay_cnt == CW'(d), req, int'(delay_cnt), d);
        chk(half_phase == p[0], req, int'(half_phase), p);
        chk(done == dn[0], req, int'(done), dn);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk) frame_pulse = 1'b1;
        @(negedge clk) frame_pulse = 1'b0;
    endtask

    // start low for npulses frame pulses, then raise it
    task automatic try_start(input int npulses);
        start = 1'b0;
        idle(2);
        for (int i = 0; i < npulses; i++) begin
            pulse();
            idle(3);
        end
        start = 1'b1;
        idle(2);
    endtask

    task automatic measure(input int h);
        try_start(2);
        chk_res("R3", 0, 0, 0);
        @(negedge clk);
        frame_pulse = 1'b1;
        eval_n = (h == 0) ? 1'b0 : 1'b1;
        for (int j = 1; j <= h; j++) begin
            @(negedge clk);
            frame_pulse = 1'b0;
            if (j == h) eval_n = 1'b0;
        end
        @(negedge clk);
        frame_pulse = 1'b0;
        eval_n = 1'b1;
        // R4 R5 R6 R7
        chk_res("R5", h / 2, (h % 2 == 0) ? 1 : 0, 1);
    endtask

    initial begin
        #(PER * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_pulse = 1'b0; eval_n = 1'b1; start = 1'b0;
        idle(3);
        chk_res("R1", 0, 0, 0);
        rst_n = 1'b1;
        idle(2);

        // R4 R5 R6: sweep every half index in a frame
        for (int h = 0; h < FRAME; h++) measure(h);

        // R7: result holds against eval_n and frame activity
        eval_n = 1'b0; idle(3); pulse(); eval_n = 1'b1; idle(2);
        chk_res("R7", 23, 0, 1);

        // R2: only one low frame pulse, start rise ignored
        try_start(1);
        @(negedge clk) frame_pulse = 1'b1; eval_n = 1'b0;
        @(negedge clk) frame_pulse = 1'b0;
        idle(3); eval_n = 1'b1;
        chk_res("R2", 23, 0, 1);
        // R2: no low frame pulse at all
        try_start(0);
        pulse(); eval_n = 1'b0; idle(3); eval_n = 1'b1;
        chk_res("R2", 23, 0, 1);

        // R8: second frame pulse without a low sample
        try_start(2);
        pulse();
        idle(20);
        chk_res("R8", 0, 0, 0);
        pulse();
        chk_res("R8", SATV, 1, 1);

        // R8: counter reaches all ones without any boundary
        try_start(2);
        pulse();
        idle(2 * (SATV + 1) + 4);
        chk_res("R8", SATV, 1, 1);

        // R9: start falls during measurement
        try_start(2);
        pulse();
        idle(3);
        start = 1'b0;
        idle(2);
        eval_n = 1'b0; idle(3); eval_n = 1'b1;
        chk_res("R9", 0, 0, 0);
        pulse(); idle(2);
        chk_res("R9", 0, 0, 0);

        // measurement after abort still works
        measure(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule